// File: doc/BRIEF.md
# Pin Interrupt Detection Controller

This block watches a port of general-purpose input pins and decides, pin by pin, when each one raises an interrupt. Every pin is first brought into the core clock domain through a chain of synchronizing flops. Each pin is then classed as edge-sensitive or level-sensitive, with a selectable polarity. An edge-sensitive pin can instead be set to fire on any transition. Edge events are latched in a raw status register until software acknowledges them. Level-sensitive status simply tracks the synchronized pin.

A mask selects which raw status bits may reach the processor. All unmasked status bits are ORed into one registered port interrupt line. One designated pin also drives a single-cycle conversion-trigger pulse toward an analog converter while that pin is unmasked. Software reaches the configuration, the two status views and the acknowledge register through a small register bus. Writes take effect at the clock edge. Reads return registered data one cycle after the request.

Top module: `gpio_irq_ctrl`

## Requirements
- R1: After reset, the sense, both-edges, event, mask, raw status and masked status registers all read 0, and `irq` and `conv_trig` are low.
- R2: A pin whose sense bit (address 0) is 1 is level-sensitive. Its raw status bit tracks its active level and ignores writes to the clear register.
- R3: The event register (address 2) selects polarity. A 1 selects a rising edge or a high level, and a 0 selects a falling edge or a low level.
- R4: An edge-sensitive pin whose both-edges bit (address 1) is 1 latches status on both rising and falling transitions, whatever its event bit holds.
- R5: The raw status register (address 4, read-only) shows every pin that meets its condition, including masked pins.
- R6: The masked status register (address 5) equals raw status AND mask (address 3, 1 = enabled). One cycle later, `irq` equals the OR of the masked status.
- R7: Writing to the clear register (address 6) clears the latched edge status of each pin whose write bit is 1. Pins whose write bit is 0 are unaffected.
- R8: When a qualifying edge arrives in the same cycle as a clear of that pin, the status bit remains set.
- R9: For an edge-sensitive trigger pin (default pin 4), each qualifying edge while the pin is unmasked gives exactly one one-cycle `conv_trig` pulse. A masked trigger pin never pulses.
- R10: For a level-sensitive trigger pin, `conv_trig` pulses once when its masked status rises, and not again while the level is held.
- R11: Rewriting the sense, both-edges or event registers while pins are masked never produces masked status or an `irq`.
- R12: A pin change is registered as raw status on the third clock edge after it, and shows on `irq` on the fourth.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Core clock |
| rst | input | 1 | Synchronous active-high reset |
| pin_in | input | NPIN | Asynchronous port pins |
| bus_sel | input | 1 | Register access request |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 3 | Register address |
| bus_wdata | input | NPIN | Write data |
| bus_rdata | output | NPIN | Registered read data |
| irq | output | 1 | Combined port interrupt |
| conv_trig | output | 1 | Converter trigger pulse from the designated pin |

## Verification
The bench builds the block with its defaults: eight pins, pin 4 as the trigger pin and two synchronizer stages. With eight pins, one configuration gives every pin a different mode: both-edge, rising, falling, and level-high and level-low pairs. A single table of port patterns therefore covers every detection path at once. Placing the trigger on pin 4 lets directed tests move that pin between edge and level sense and between masked and unmasked. A fixed two-stage synchronizer makes the edge latency exact, so a clear can be timed to land in the same cycle as a new edge.

// File: rtl/gpio_irq_pkg.sv
package gpio_irq_pkg;
  localparam int ADDR_W = 3;

  typedef enum logic [ADDR_W-1:0] {
    REG_SENSE    = 3'd0,
    REG_BOTH     = 3'd1,
    REG_EVENT    = 3'd2,
    REG_MASK     = 3'd3,
    REG_RAW      = 3'd4,
    REG_MSK_STAT = 3'd5,
    REG_CLEAR    = 3'd6
  } reg_addr_e;
endpackage

// File: rtl/gpio_irq_sync.sv
module gpio_irq_sync #(
  parameter int W      = 8,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] pin_in,
  output logic [W-1:0] sync_o,
  output logic [W-1:0] prev_o
);
  logic [W-1:0] chain [STAGES];

  generate
    for (genvar k = 0; k < STAGES; k++) begin : g_stage
      if (k == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (rst) chain[k] <= '0;
          else     chain[k] <= pin_in;
        end
      end else begin : g_next
        always_ff @(posedge clk) begin
          if (rst) chain[k] <= '0;
          else     chain[k] <= chain[k-1];
        end
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) prev_o <= '0;
    else     prev_o <= chain[STAGES-1];
  end

  assign sync_o = chain[STAGES-1];
endmodule

// File: rtl/gpio_irq_detect.sv
module gpio_irq_detect #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] cur_i,
  input  logic [W-1:0] prev_i,
  input  logic [W-1:0] sense_i,
  input  logic [W-1:0] both_i,
  input  logic [W-1:0] evt_i,
  input  logic [W-1:0] clr_i,
  output logic [W-1:0] hit_o,
  output logic [W-1:0] cond_o,
  output logic [W-1:0] raw_o
);
  generate
    for (genvar i = 0; i < W; i++) begin : g_pin
      logic rise, fall, raw_bit;

      assign rise      = cur_i[i] & ~prev_i[i];
      assign fall      = ~cur_i[i] & prev_i[i];
      assign hit_o[i]  = ~sense_i[i] &
                         (both_i[i] ? (rise | fall) : (evt_i[i] ? rise : fall));
      assign cond_o[i] = (cur_i[i] == evt_i[i]);

      always_ff @(posedge clk) begin
        if (rst)             raw_bit <= 1'b0;
        else if (sense_i[i]) raw_bit <= cond_o[i];
        else                 raw_bit <= hit_o[i] | (raw_bit & ~clr_i[i]);
      end

      assign raw_o[i] = raw_bit;
    end
  endgenerate
endmodule

// File: rtl/gpio_irq_regs.sv
module gpio_irq_regs
  import gpio_irq_pkg::*;
#(
  parameter int W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              sel,
  input  logic              wr,
  input  logic [ADDR_W-1:0] addr,
  input  logic [W-1:0]      wdata,
  input  logic [W-1:0]      raw_i,
  output logic [W-1:0]      sense_o,
  output logic [W-1:0]      both_o,
  output logic [W-1:0]      evt_o,
  output logic [W-1:0]      mask_o,
  output logic [W-1:0]      clr_o,
  output logic [W-1:0]      rdata_o
);
  reg_addr_e  a;
  logic       wr_go, rd_go;
  logic [W-1:0] rd_mux;

  assign a     = reg_addr_e'(addr);
  assign wr_go = sel & wr;
  assign rd_go = sel & ~wr;
  assign clr_o = (wr_go && a == REG_CLEAR) ? wdata : '0;

  always_ff @(posedge clk) begin
    if (rst) begin
      sense_o <= '0;
      both_o  <= '0;
      evt_o   <= '0;
      mask_o  <= '0;
    end else if (wr_go) begin
      case (a)
        REG_SENSE: sense_o <= wdata;
        REG_BOTH:  both_o  <= wdata;
        REG_EVENT: evt_o   <= wdata;
        REG_MASK:  mask_o  <= wdata;
        default: ;
      endcase
    end
  end

  always_comb begin
    case (a)
      REG_SENSE:    rd_mux = sense_o;
      REG_BOTH:     rd_mux = both_o;
      REG_EVENT:    rd_mux = evt_o;
      REG_MASK:     rd_mux = mask_o;
      REG_RAW:      rd_mux = raw_i;
      REG_MSK_STAT: rd_mux = raw_i & mask_o;
      default:      rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst)        rdata_o <= '0;
    else if (rd_go) rdata_o <= rd_mux;
  end
endmodule

// File: rtl/gpio_irq_ctrl.sv
module gpio_irq_ctrl
  import gpio_irq_pkg::*;
#(
  parameter int NPIN        = 8,
  parameter int TRIG_PIN    = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [NPIN-1:0]   pin_in,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [NPIN-1:0]   bus_wdata,
  output logic [NPIN-1:0]   bus_rdata,
  output logic              irq,
  output logic              conv_trig
);
  logic [NPIN-1:0] pin_s, pin_p;
  logic [NPIN-1:0] sense_q, both_q, evt_q, mask_q, clr;
  logic [NPIN-1:0] hit, cond, raw, masked;
  logic            masked_trig_q, trig_d;

  gpio_irq_sync #(.W(NPIN), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .pin_in(pin_in), .sync_o(pin_s), .prev_o(pin_p)
  );

  gpio_irq_detect #(.W(NPIN)) u_det (
    .clk(clk), .rst(rst), .cur_i(pin_s), .prev_i(pin_p),
    .sense_i(sense_q), .both_i(both_q), .evt_i(evt_q), .clr_i(clr),
    .hit_o(hit), .cond_o(cond), .raw_o(raw)
  );

  gpio_irq_regs #(.W(NPIN)) u_regs (
    .clk(clk), .rst(rst), .sel(bus_sel), .wr(bus_wr), .addr(bus_addr),
    .wdata(bus_wdata), .raw_i(raw), .sense_o(sense_q), .both_o(both_q),
    .evt_o(evt_q), .mask_o(mask_q), .clr_o(clr), .rdata_o(bus_rdata)
  );

  assign masked = raw & mask_q;

  // Edge-sensed trigger pin: pulse on each qualifying edge.
  // Level-sensed trigger pin: pulse on the rise of its masked status.
  assign trig_d = sense_q[TRIG_PIN] ? (masked[TRIG_PIN] & ~masked_trig_q)
                                    : (hit[TRIG_PIN] & mask_q[TRIG_PIN]);

  always_ff @(posedge clk) begin
    if (rst) begin
      irq           <= 1'b0;
      conv_trig     <= 1'b0;
      masked_trig_q <= 1'b0;
    end else begin
      irq           <= |masked;
      conv_trig     <= trig_d;
      masked_trig_q <= masked[TRIG_PIN];
    end
  end
endmodule

// File: rtl/gpio_irq_chk.sv
module gpio_irq_chk
  import gpio_irq_pkg::*;
#(
  parameter int NPIN     = 8,
  parameter int TRIG_PIN = 4
) (
  input logic              clk,
  input logic              rst,
  input logic              bus_sel,
  input logic              bus_wr,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [NPIN-1:0]   bus_wdata,
  input logic [NPIN-1:0]   sense,
  input logic [NPIN-1:0]   mask,
  input logic [NPIN-1:0]   hit,
  input logic [NPIN-1:0]   cond,
  input logic [NPIN-1:0]   raw,
  input logic              irq,
  input logic              conv_trig
);
  logic clr_wr;
  assign clr_wr = bus_sel & bus_wr & (bus_addr == REG_CLEAR);

  // R2
  level_follow_chk: assert property (@(posedge clk) disable iff (rst)
    ((raw ^ $past(cond)) & $past(sense)) == '0);

  // R6
  irq_set_chk: assert property (@(posedge clk) disable iff (rst)
    (|(raw & mask)) |=> irq);

  // R6
  irq_clr_chk: assert property (@(posedge clk) disable iff (rst)
    !(|(raw & mask)) |=> !irq);

  // R7
  clear_takes_chk: assert property (@(posedge clk) disable iff (rst)
    (clr_wr && |(bus_wdata & ~sense & ~hit)) |=>
      ((raw & $past(bus_wdata & ~sense & ~hit)) == '0));

  // R8
  hit_wins_chk: assert property (@(posedge clk) disable iff (rst)
    (|(hit & ~sense)) |=> ((raw & $past(hit & ~sense)) == $past(hit & ~sense)));

  // R9
  trig_masked_chk: assert property (@(posedge clk) disable iff (rst)
    conv_trig |-> $past(mask[TRIG_PIN]));
endmodule

bind gpio_irq_ctrl gpio_irq_chk #(.NPIN(NPIN), .TRIG_PIN(TRIG_PIN)) u_chk (
  .clk(clk), .rst(rst), .bus_sel(bus_sel), .bus_wr(bus_wr),
  .bus_addr(bus_addr), .bus_wdata(bus_wdata), .sense(sense_q),
  .mask(mask_q), .hit(hit), .cond(cond), .raw(raw), .irq(irq),
  .conv_trig(conv_trig)
);

// File: tb/gpio_irq_ctrl_test.sv
module gpio_irq_ctrl_test;
  import gpio_irq_pkg::*;

  localparam int NPIN = 8;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic [NPIN-1:0]   pin_in = '0;
  logic              bus_sel = 1'b0;
  logic              bus_wr = 1'b0;
  logic [ADDR_W-1:0] bus_addr = '0;
  logic [NPIN-1:0]   bus_wdata = '0;
  logic [NPIN-1:0]   bus_rdata;
  logic              irq, conv_trig;

  int checks = 0;
  int errors = 0;
  int trig_cnt = 0;
  int irq_cnt = 0;

  always #10 clk = ~clk;

  gpio_irq_ctrl uut (
    .clk(clk), .rst(rst), .pin_in(pin_in), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .irq(irq), .conv_trig(conv_trig)
  );

  always @(negedge clk) begin
    if (!rst && conv_trig) trig_cnt++;
    if (!rst && irq)       irq_cnt++;
  end

  // {pin pattern, expected raw status}; pins 0,1 both-edge, 2 rising, 3 falling,
  // 4 low level, 5 high level, 6 low level, 7 high level
  localparam logic [15:0] STEPS [0:5] = '{
    16'h0F57, 16'h005B, 16'hF0A0, 16'h5A02, 16'hA5FF, 16'hA5F0
  };

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    for (int k = 0; k < n; k++) @(negedge clk);
  endtask

  task automatic wr_reg(input reg_addr_e a, input logic [NPIN-1:0] d);
    bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_sel = 1'b0; bus_wr = 1'b0;
  endtask

  task automatic rd_reg(input reg_addr_e a, output logic [NPIN-1:0] d);
    bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
    @(negedge clk);
    bus_sel = 1'b0;
    d = bus_rdata;
  endtask

  task automatic config4(input logic [7:0] s, input logic [7:0] b,
                         input logic [7:0] e, input logic [7:0] m);
    wr_reg(REG_MASK, 8'h00);
    wr_reg(REG_SENSE, s);
    wr_reg(REG_BOTH, b);
    wr_reg(REG_EVENT, e);
    cyc(4);
    wr_reg(REG_CLEAR, 8'hFF);
    wr_reg(REG_MASK, m);
  endtask

  initial begin
    logic [NPIN-1:0] d;
    int base;
    int ibase;

    cyc(3);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    chk("R1 irq", irq, 0);
    chk("R1 conv_trig", conv_trig, 0);
    for (int r = 0; r < 6; r++) begin
      rd_reg(reg_addr_e'(r), d);
      chk("R1 register", d, 0);
    end

    // Table: R2 R3 R4 R5 with every pin masked
    config4(8'hF0, 8'h03, 8'hA5, 8'h00);
    base = trig_cnt;
    for (int i = 0; i < 6; i++) begin
      pin_in = STEPS[i][15:8];
      cyc(5);
      rd_reg(REG_RAW, d);
      chk("R5 raw table", d, STEPS[i][7:0]);
      rd_reg(REG_MSK_STAT, d);
      chk("R6 masked table", d, 0);
      chk("R6 irq masked", irq, 0);
      wr_reg(REG_CLEAR, 8'hFF);
      rd_reg(REG_RAW, d);
      chk("R2 level bits ignore clear", d, STEPS[i][7:0] & 8'hF0);
    end
    chk("R9 masked trigger silent", trig_cnt - base, 0);

    // R12 latency and R6 irq
    pin_in = 8'h00;
    config4(8'h00, 8'h00, 8'h01, 8'h01);
    pin_in = 8'h01;
    cyc(3);
    chk("R12 irq low at third edge", irq, 0);
    cyc(1);
    chk("R12 irq high at fourth edge", irq, 1);
    rd_reg(REG_MSK_STAT, d);
    chk("R6 masked status", d, 8'h01);

    // R7 clear
    wr_reg(REG_CLEAR, 8'h00);
    rd_reg(REG_RAW, d);
    chk("R7 zero write keeps status", d, 8'h01);
    wr_reg(REG_CLEAR, 8'h01);
    @(negedge clk);
    chk("R7 irq drops after clear", irq, 0);
    rd_reg(REG_RAW, d);
    chk("R7 one write clears", d, 8'h00);

    // R3 falling edge not qualifying for rising pin
    pin_in = 8'h00;
    cyc(5);
    rd_reg(REG_RAW, d);
    chk("R3 falling ignored on rising pin", d, 8'h00);

    // R8 edge and clear in the same cycle
    pin_in = 8'h01;
    cyc(2);
    bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = REG_CLEAR; bus_wdata = 8'h01;
    @(negedge clk);
    bus_sel = 1'b0; bus_wr = 1'b0;
    rd_reg(REG_RAW, d);
    chk("R8 edge wins over clear", d, 8'h01);

    // R9 edge trigger on pin 4
    pin_in = 8'h00;
    config4(8'h00, 8'h00, 8'h10, 8'h10);
    base = trig_cnt;
    pin_in = 8'h10;
    cyc(6);
    chk("R9 one pulse per rise", trig_cnt - base, 1);
    pin_in = 8'h00;
    cyc(6);
    chk("R9 no pulse on falling", trig_cnt - base, 1);
    wr_reg(REG_MASK, 8'h00);
    pin_in = 8'h10;
    cyc(6);
    chk("R9 masked pin no pulse", trig_cnt - base, 1);

    // R10 level trigger on pin 4
    pin_in = 8'h00;
    config4(8'h10, 8'h00, 8'h10, 8'h10);
    base = trig_cnt;
    pin_in = 8'h10;
    cyc(10);
    chk("R10 single pulse for held level", trig_cnt - base, 1);
    chk("R2 level irq", irq, 1);
    pin_in = 8'h00;
    cyc(5);
    chk("R2 level removed", irq, 0);
    pin_in = 8'h10;
    cyc(6);
    chk("R10 new level pulse", trig_cnt - base, 2);

    // R11 configuration churn while masked
    wr_reg(REG_MASK, 8'h00);
    pin_in = 8'h5C;
    cyc(6);
    ibase = irq_cnt;
    wr_reg(REG_SENSE, 8'hFF);
    wr_reg(REG_EVENT, 8'h00);
    wr_reg(REG_BOTH, 8'hFF);
    wr_reg(REG_EVENT, 8'hFF);
    wr_reg(REG_SENSE, 8'h00);
    wr_reg(REG_EVENT, 8'h33);
    cyc(4);
    rd_reg(REG_MSK_STAT, d);
    chk("R11 masked status stays clear", d, 0);
    chk("R11 no irq during churn", irq_cnt - ibase, 0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #4000000;
    errors++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule